// File: doc/BRIEF.md
# ROM Signature Stream Scanner

This block locates a fixed byte pattern in the output of a station-address ROM that is read one byte at a time. The ROM has its own address counter, and that counter can start at any position. After a start request the block issues a single throwaway read to settle the ROM counter. It then reads bytes one at a time and feeds each into a pattern tracker. The tracker keeps a match index. On a mismatch the index restarts at one when the offending byte equals the pattern's first byte, and at zero in every other case. The search has a fixed read budget. If that budget runs out before the whole pattern is seen, the block reports a timeout.

The block stops reading on the exact read that completes the pattern, so the ROM counter is left on the first identifier byte. It then reads the station identifier bytes and a multi-byte check word, and holds them on its outputs. A one-cycle completion pulse marks the end of each search, and a found or a timeout flag goes with it. The flags and the captured fields hold their values until the next accepted start.

Top module: `sig_scan_top`

## Requirements
- R1: Out of reset, rd_stb, done, found and timeout are 0, and station_id and id_sum are all zero.
- R2: The first strobe after an accepted start is a throwaway read. Its data is never compared against the pattern.
- R3: Each read is a strobe exactly one cycle wide, and two strobes are never in adjacent cycles. rd_data is sampled in the cycle after its strobe.
- R4: The pattern is the 8 bytes FF, 00, 55, AA, FF, 00, 55, AA in read order. A match advances the index. A mismatch sets the index to 1 if the byte is FF and to 0 otherwise.
- R5: Once the eighth pattern byte matches, no more search reads are issued. Exactly 8 further strobes follow, and after them no strobe is issued until the next start.
- R6: At most 39 search reads are made. A match completed on the 39th read counts as found. Otherwise, after the 39th read, done and timeout rise together with no capture reads, so the total strobe count is 40.
- R7: done is a one-cycle pulse. In that cycle exactly one of found or timeout is 1, and neither flag rises in any other cycle.
- R8: found, timeout, station_id and id_sum hold between the end of a search and the next accepted start. A start input while a search is running is ignored.
- R9: The 6 bytes after the pattern fill station_id with the first byte read in bits 47:40. The 2 bytes after those fill id_sum, low byte first.
- R10: After a timeout, station_id and id_sum are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search when idle |
| rd_data | input | 8 | ROM byte, valid in the cycle after its strobe |
| rd_stb | output | 1 | One-cycle read request to the ROM |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Pattern located and fields captured |
| timeout | output | 1 | Read budget spent without a match |
| station_id | output | 48 | Captured identifier, first byte read in the top byte |
| id_sum | output | 16 | Captured check word, low byte first |

## Verification
The completing match and the end of the read budget can land on the same read, the 39th. In that case the match must win and capture must follow. Directed ROM images place the pattern so that it ends on read 39 (found expected) and on read 40 (timeout expected). In both cases the bench counts strobes and compares the captured fields with a reference scan built into the bench. A second overlap is a start pulse that arrives in the middle of a search. The bench judges that it was ignored when the strobe total and the captured fields match the result of a search with no such pulse.

// File: rtl/sig_scan_pkg.sv
package sig_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLR,
      ST_CLR_W,
      ST_SRCH,
      ST_SRCH_W,
      ST_CAP,
      ST_CAP_W
   } scan_st_e;

endpackage

// File: rtl/sig_track.sv
module sig_track #(
   parameter int DW               = 8,
   parameter int SIG_BYTES        = 8,
   parameter logic [SIG_BYTES*DW-1:0] SIG_PAT = '1,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp,
   input  logic [DW-1:0] byte_in,
   output logic          hit
);

   localparam int IW = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1;

   logic [IW-1:0] idx;
   logic [DW-1:0] want;
   logic          eq;
   logic          first_eq;

   assign want = SIG_PAT[idx*DW +: DW];
   assign eq   = (byte_in == want);
   assign hit  = eq && (idx == IW'(SIG_BYTES-1));

   generate
      if (RESTART_ON_FIRST) begin : g_restart
         assign first_eq = (byte_in == SIG_PAT[DW-1:0]);
      end else begin : g_plain
         assign first_eq = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (smp) begin
         if (hit)           idx <= '0;
         else if (eq)       idx <= idx + IW'(1);
         else if (first_eq) idx <= IW'(1);
         else               idx <= '0;
      end
   end

endmodule

// File: rtl/win_counter.sv
module win_counter #(
   parameter int LIMIT = 39
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/field_capture.sv
module field_capture #(
   parameter int DW        = 8,
   parameter int ID_BYTES  = 6,
   parameter int SUM_BYTES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    smp,
   input  logic [DW-1:0]           byte_in,
   output logic                    last,
   output logic [ID_BYTES*DW-1:0]  id_o,
   output logic [SUM_BYTES*DW-1:0] sum_o
);

   localparam int NB = ID_BYTES + SUM_BYTES;
   localparam int CW = (NB > 1) ? $clog2(NB) : 1;

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(NB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (smp)    cnt <= cnt + CW'(1);
   end

   generate
      for (genvar k = 0; k < NB; k++) begin : g_byte
         logic [DW-1:0] b;
         always_ff @(posedge clk) begin
            if (!rst_n)                        b <= '0;
            else if (clr)                      b <= '0;
            else if (smp && cnt == CW'(k))     b <= byte_in;
         end
         if (k < ID_BYTES) begin : g_id
            assign id_o[(ID_BYTES-1-k)*DW +: DW] = b;
         end else begin : g_sum
            assign sum_o[(k-ID_BYTES)*DW +: DW] = b;
         end
      end
   endgenerate

endmodule

// File: rtl/sig_scan_top.sv
module sig_scan_top #(
   parameter int DW          = 8,
   parameter int SIG_BYTES   = 8,
   parameter logic [SIG_BYTES*DW-1:0] SIG_PAT = 64'hAA55_00FF_AA55_00FF,
   parameter int SLACK_READS = 32,
   parameter int ID_BYTES    = 6,
   parameter int SUM_BYTES   = 2,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [DW-1:0]           rd_data,
   output logic                    rd_stb,
   output logic                    done,
   output logic                    found,
   output logic                    timeout,
   output logic [ID_BYTES*DW-1:0]  station_id,
   output logic [SUM_BYTES*DW-1:0] id_sum
);

   import sig_scan_pkg::*;

   localparam int SCAN_LIMIT = SLACK_READS + SIG_BYTES - 1;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("sig_scan_top: DW must be at least 1");
      end
      if (SIG_BYTES < 2) begin : g_bad_sig
         $error("sig_scan_top: SIG_BYTES must be at least 2");
      end
      if (SLACK_READS < 1) begin : g_bad_slack
         $error("sig_scan_top: SLACK_READS must be at least 1");
      end
      if (ID_BYTES < 1 || SUM_BYTES < 1) begin : g_bad_fields
         $error("sig_scan_top: ID_BYTES and SUM_BYTES must be at least 1");
      end
   endgenerate

   scan_st_e st;
   logic     go;
   logic     smp_srch;
   logic     smp_cap;
   logic     hit;
   logic     win_last;
   logic     cap_last;

   assign go       = (st == ST_IDLE) && start;
   assign smp_srch = (st == ST_SRCH_W);
   assign smp_cap  = (st == ST_CAP_W);
   assign rd_stb   = (st == ST_CLR) || (st == ST_SRCH) || (st == ST_CAP);

   sig_track #(
      .DW               (DW),
      .SIG_BYTES        (SIG_BYTES),
      .SIG_PAT          (SIG_PAT),
      .RESTART_ON_FIRST (RESTART_ON_FIRST)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go),
      .smp     (smp_srch),
      .byte_in (rd_data),
      .hit     (hit)
   );

   win_counter #(
      .LIMIT (SCAN_LIMIT)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .inc   (smp_srch),
      .last  (win_last)
   );

   field_capture #(
      .DW        (DW),
      .ID_BYTES  (ID_BYTES),
      .SUM_BYTES (SUM_BYTES)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go),
      .smp     (smp_cap),
      .byte_in (rd_data),
      .last    (cap_last),
      .id_o    (station_id),
      .sum_o   (id_sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         done    <= 1'b0;
         found   <= 1'b0;
         timeout <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  found   <= 1'b0;
                  timeout <= 1'b0;
                  st      <= ST_CLR;
               end
            end
            ST_CLR:   st <= ST_CLR_W;
            ST_CLR_W: st <= ST_SRCH;
            ST_SRCH:  st <= ST_SRCH_W;
            ST_SRCH_W: begin
               if (hit) begin
                  st <= ST_CAP;
               end else if (win_last) begin
                  timeout <= 1'b1;
                  done    <= 1'b1;
                  st      <= ST_IDLE;
               end else begin
                  st <= ST_SRCH;
               end
            end
            ST_CAP:   st <= ST_CAP_W;
            ST_CAP_W: begin
               if (cap_last) begin
                  found <= 1'b1;
                  done  <= 1'b1;
                  st    <= ST_IDLE;
               end else begin
                  st <= ST_CAP;
               end
            end
            default:  st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sig_scan_chk.sv
module sig_scan_chk #(
   parameter int MAX_STB = 48
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic rd_stb,
   input logic done,
   input logic found,
   input logic timeout
);

   logic        busy;
   logic [15:0] stb_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         stb_cnt <= '0;
      end else begin
         if (done || !busy) begin
            if (start) begin
               busy    <= 1'b1;
               stb_cnt <= '0;
            end else begin
               busy <= 1'b0;
            end
         end else if (rd_stb) begin
            stb_cnt <= stb_cnt + 16'd1;
         end
      end
   end

   AST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);                                            // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R7
   AST_DONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (found ^ timeout));                                    // R7
   AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(found) || $rose(timeout)) |-> done);                     // R7
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(start)) |-> ($stable(found) && $stable(timeout))); // R8
   AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (stb_cnt <= 16'(MAX_STB)));                            // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_stb);                                             // R5

endmodule

bind sig_scan_top sig_scan_chk #(
   .MAX_STB (1 + SLACK_READS + SIG_BYTES - 1 + ID_BYTES + SUM_BYTES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .rd_stb  (rd_stb),
   .done    (done),
   .found   (found),
   .timeout (timeout)
);

// File: tb/sig_scan_top_tb.sv
`timescale 1ns/1ps
module sig_scan_top_tb;

   localparam logic [63:0] PAT = 64'hAA55_00FF_AA55_00FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  rd_data = 8'h00;
   logic        rd_stb;
   logic        done;
   logic        found;
   logic        timeout;
   logic [47:0] station_id;
   logic [15:0] id_sum;

   logic [7:0]  rom [0:63];
   int          rom_len = 32;
   int          ptr = 0;
   int          stb_cnt = 0;
   logic        ld = 1'b0;
   int          ld_ofs = 0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   sig_scan_top u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rd_data    (rd_data),
      .rd_stb     (rd_stb),
      .done       (done),
      .found      (found),
      .timeout    (timeout),
      .station_id (station_id),
      .id_sum     (id_sum)
   );

   always @(posedge clk) begin
      if (ld) begin
         ptr     <= ld_ofs;
         stb_cnt <= 0;
      end else if (rd_stb) begin
         rd_data <= rom[ptr];
         ptr     <= (ptr + 1) % rom_len;
         stb_cnt <= stb_cnt + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat_byte(input int j);
      return PAT[j*8 +: 8];
   endfunction

   task automatic predict(input int ofs, output bit f, output logic [47:0] a,
                          output logic [15:0] s, output int reads);
      int p;
      int j;
      int n;
      logic [7:0] b;
      p = (ofs + 1) % rom_len;
      j = 0;
      n = 0;
      f = 1'b0;
      a = '0;
      s = '0;
      while (n < 39 && j < 8) begin
         b = rom[p];
         p = (p + 1) % rom_len;
         n = n + 1;
         if (b == pat_byte(j)) j = j + 1;
         else j = (b == pat_byte(0)) ? 1 : 0;
      end
      reads = 1 + n;
      if (j == 8) begin
         f = 1'b1;
         for (int k = 0; k < 6; k++) begin
            a[(5-k)*8 +: 8] = rom[p];
            p = (p + 1) % rom_len;
         end
         for (int k = 0; k < 2; k++) begin
            s[k*8 +: 8] = rom[p];
            p = (p + 1) % rom_len;
         end
         reads = reads + 8;
      end
   endtask

   task automatic fill_rom(input int len, input logic [7:0] v);
      rom_len = len;
      for (int i = 0; i < 64; i++) rom[i] = v;
   endtask

   task automatic put_pat(input int at);
      for (int i = 0; i < 8; i++) rom[(at + i) % rom_len] = pat_byte(i);
   endtask

   task automatic put_fields(input int at);
      for (int i = 0; i < 8; i++) rom[(at + i) % rom_len] = 8'($urandom);
   endtask

   task automatic run_case(input string tag, input int ofs, input bit poke);
      bit          ef;
      logic [47:0] ea;
      logic [15:0] es;
      int          er;
      int          n;
      logic        f_s;
      logic        t_s;
      logic [47:0] a_s;
      logic [15:0] s_s;
      int          c_s;
      ld_ofs = ofs;
      ld = 1'b1;
      @(negedge clk);
      ld = 1'b0;
      predict(ofs, ef, ea, es, er);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      if (poke) begin
         repeat (9) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         n = 10;
      end
      while (!done && n < 500) begin
         @(negedge clk);
         n = n + 1;
      end
      chk({tag, " R7 done seen"}, 64'(done), 64'd1);
      chk({tag, " R4 R6 found"}, 64'(found), 64'(ef));
      chk({tag, " R6 timeout"}, 64'(timeout), 64'(!ef));
      chk({tag, " R9 R10 station_id"}, 64'(station_id), 64'(ea));
      chk({tag, " R9 R10 id_sum"}, 64'(id_sum), 64'(es));
      chk({tag, " R2 R5 strobe count"}, 64'(stb_cnt), 64'(er));
      f_s = found; t_s = timeout; a_s = station_id; s_s = id_sum; c_s = stb_cnt;
      @(negedge clk);
      chk({tag, " R7 done one cycle"}, 64'(done), 64'd0);
      repeat (12) @(negedge clk);
      chk({tag, " R8 flags hold"}, {62'd0, found, timeout}, {62'd0, f_s, t_s});
      chk({tag, " R8 fields hold"}, {a_s ^ station_id, s_s ^ id_sum}, 64'd0);
      chk({tag, " R5 no reads when idle"}, 64'(stb_cnt), 64'(c_s));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fill_rom(32, 8'h11);
      repeat (4) @(negedge clk);
      chk("R1 reset flags", {60'd0, rd_stb, done, found, timeout}, 64'd0);
      chk("R1 reset fields", {station_id, id_sum}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: match completes on search read 39
      fill_rom(48, 8'h11); put_pat(32); put_fields(40);
      run_case("edge39", 0, 1'b0);

      // R6: match would complete on read 40, so the budget ends first
      fill_rom(48, 8'h11); put_pat(33); put_fields(41);
      run_case("edge40", 0, 1'b0);

      // R2: throwaway byte is the leading pattern byte; the rest follows
      fill_rom(48, 8'h11); put_pat(3); put_fields(11);
      run_case("dummy", 3, 1'b0);

      // R4: mismatch on pattern byte FF restarts at index 1
      fill_rom(48, 8'h11);
      rom[5] = 8'hFF; rom[6] = 8'h00; rom[7] = 8'h55;
      put_pat(8); put_fields(16);
      run_case("restart_a", 0, 1'b0);

      // R4: repeated leading byte
      fill_rom(48, 8'h11);
      rom[4] = 8'hFF;
      put_pat(5); put_fields(13);
      run_case("restart_b", 0, 1'b0);

      // R8: start pulse in mid search is ignored
      fill_rom(32, 8'h22); put_pat(10); put_fields(18);
      run_case("busy_start", 6, 1'b1);

      for (int t = 0; t < 40; t++) begin
         fill_rom(32, 8'h00);
         for (int i = 16; i < 32; i++) begin
            if ($urandom_range(1, 0) == 1) rom[i] = pat_byte(int'($urandom_range(7, 0)));
            else rom[i] = 8'($urandom);
         end
         put_pat(0); put_fields(8);
         if ($urandom_range(3, 0) == 0) rom[$urandom_range(7, 0)] = 8'h33;
         run_case($sformatf("rnd%0d", t), int'($urandom_range(31, 0)), 1'b0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule